// File: doc/BRIEF.md
# Bit-Serial Accumulator Arithmetic Unit

This block is a 32-bit two's complement arithmetic unit with a datapath one bit wide. It keeps a word accumulator and a word data register. Both are held as circulating shift registers, so each one rotates by one position on every bit tick. An operand arrives one bit per tick, least significant bit first. A word operation takes one word period of 32 bit ticks. A strobe marks bit 0 of each word, and the operation select is sampled at that strobe.

On every tick the accumulator presents its current low bit on the serial result output. That bit is the accumulator bit with the same index as the tick, taken from the value the accumulator held at the start of the word. A store operation is therefore just a read of that output while the accumulator keeps its value. Addition and subtraction use one full-adder slice with a carry flip-flop. An arithmetic shift or a rotation moves the accumulator right by one position per word pass, so a shift by n takes n passes. A sign flag follows the accumulator's top bit and changes only at the end of each word, ready for a conditional branch.

Top module: `serial_acc_alu`

## Requirements
- R1: After a synchronous active-low reset the accumulator, the data register, `sign_flag` and `res_bit` are all zero.
- R2: `word_start`, when high together with `bit_en`, marks tick 0 of a word, and `op_sel` is sampled only on that tick. A word spans 32 ticks, least significant bit first. On a cycle with `bit_en` low no state changes, whatever the other inputs are.
- R3: LOAD (`op_sel`=1) makes the accumulator equal to the operand word.
- R4: ADD (`op_sel`=2) makes the accumulator equal to accumulator plus operand, modulo 2^32.
- R5: SUB (`op_sel`=3) makes the accumulator equal to accumulator minus operand, modulo 2^32.
- R6: On tick k of any word, `res_bit` equals bit k of the accumulator as it was at the start of that word. STORE (`op_sel`=4) leaves the accumulator unchanged.
- R7: ASR (`op_sel`=5) shifts the accumulator right arithmetically by one position per word pass and copies bit 31 into the top. n passes shift it by n.
- R8: ROR (`op_sel`=6) rotates the accumulator right by one position per word pass, so old bit 0 becomes bit 31.
- R9: The data register takes the operand word during LOAD, ADD and SUB and keeps its value during every other operation. RELOAD (`op_sel`=7) copies the data register into the accumulator.
- R10: `sign_flag` equals bit 31 of the accumulator once the last tick of a word has been processed, and changes at no other time.
- R11: NOP (`op_sel`=0) leaves the accumulator and the data register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Bit-clock enable; one serial step per high cycle |
| word_start | input | 1 | Marks tick 0 of a word (valid only while bit_en is high) |
| op_sel | input | 3 | Operation code, sampled at word_start |
| op_bit | input | 1 | Serial operand bit, LSB first |
| res_bit | output | 1 | Serial accumulator bit for the current tick |
| sign_flag | output | 1 | Accumulator bit 31 as of the last completed word |

## Verification
A wrong carry, a wrong tap or a misaligned bit index does not show at once. It shows one word later, when the next word streams the accumulator out on `res_bit`, and the first bad bit gives the tick at which the error began. A sign flag updated at the wrong moment shows within one tick, because its value is compared on every clock. A data register that drifts out of alignment shows only after a RELOAD followed by a readout word, so those pairs are run after stalls and after non-capturing operations.

// File: rtl/serial_alu_pkg.sv
// Package: operation codes shared by the serial arithmetic unit and its bench.
// Assumes a 3-bit operation select.
package serial_alu_pkg;
    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_LOAD   = 3'd1,
        OP_ADD    = 3'd2,
        OP_SUB    = 3'd3,
        OP_STORE  = 3'd4,
        OP_ASR    = 3'd5,
        OP_ROR    = 3'd6,
        OP_RELOAD = 3'd7
    } alu_op_e;
endpackage

// File: rtl/word_phase_ctr.sv
// Bit-position counter inside a word.
// Does: gives the index of the tick being processed (0 on a framing tick),
//       and flags the last tick of the word.
// Assumes: frame is only meaningful while tick is high.
module word_phase_ctr #(
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             frame,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    logic [IDX_W-1:0] cnt_q;

    // current index: a framing tick restarts at zero
    always_comb begin
        idx  = frame ? '0 : cnt_q;
        last = (idx == IDX_W'(WORD_W - 1));
    end

    // advance once per tick, wrapping at the word length
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= last ? '0 : idx + 1'b1;
    end

    // R2
    cnt_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));
    // R2
    cnt_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && frame) |=> (cnt_q == IDX_W'(1)));
endmodule

// File: rtl/serial_word_reg.sv
// Circulating word register.
// Does: on each enabled cycle shifts right by one, taking din at the top bit.
//       Bit 0 is the bit currently presented to the serial datapath.
// Assumes: the caller feeds bit 0 back in when it wants to keep the word.
module serial_word_reg #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              din,
    output logic [WORD_W-1:0] q
);
    // shift one position per enabled tick
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (shift_en)
            q <= {din, q[WORD_W-1:1]};
    end

    // R2
    reg_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(q));
endmodule

// File: rtl/serial_add_slice.sv
// One-bit adder slice with a carry flip-flop.
// Does: a + (b ^ invert_b) + carry, one bit per tick. On the first tick of a
//       word the carry in is invert_b, which gives subtraction as add-inverse+1.
// Assumes: bits arrive least significant first.
module serial_add_slice (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic first,
    input  logic invert_b,
    input  logic a,
    input  logic b,
    output logic sum
);
    logic carry_q;
    logic cin;
    logic bx;
    logic cout;

    // full-adder equations for the current bit
    always_comb begin
        cin  = first ? invert_b : carry_q;
        bx   = b ^ invert_b;
        sum  = a ^ bx ^ cin;
        cout = (a & bx) | (a & cin) | (bx & cin);
    end

    // carry carried forward to the next bit
    always_ff @(posedge clk) begin
        if (!rst_n)
            carry_q <= 1'b0;
        else if (tick)
            carry_q <= cout;
    end

    // R5
    carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(carry_q));
endmodule

// File: rtl/serial_acc_alu.sv
// Bit-serial accumulator arithmetic unit (top).
// Does: load/add/subtract/store/arithmetic shift/rotate on a circulating
//       accumulator, one bit per bit_en tick, LSB first, WORD_W ticks per word.
// Assumes: every word starts with word_start and gets exactly WORD_W ticks.
module serial_acc_alu
    import serial_alu_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       word_start,
    input  logic [2:0] op_sel,
    input  logic       op_bit,
    output logic       res_bit,
    output logic       sign_flag
);
    logic              frame;
    logic [IDX_W-1:0]  idx;
    logic              last;
    alu_op_e           op_q;
    alu_op_e           cur_op;
    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] data_q;
    logic              acc_din;
    logic              data_din;
    logic              capture;
    logic              add_sum;
    logic              rot_lsb_q;

    assign frame = bit_en & word_start;

    word_phase_ctr #(.WORD_W(WORD_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (bit_en),
        .frame (frame),
        .idx   (idx),
        .last  (last)
    );

    // operation in force this tick: the select input on a framing tick
    always_comb begin
        cur_op  = frame ? alu_op_e'(op_sel) : op_q;
        capture = (cur_op == OP_LOAD) || (cur_op == OP_ADD) || (cur_op == OP_SUB);
    end

    // hold the sampled operation for the rest of the word
    always_ff @(posedge clk) begin
        if (!rst_n)
            op_q <= OP_NOP;
        else if (frame)
            op_q <= alu_op_e'(op_sel);
    end

    serial_add_slice u_adder (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (bit_en),
        .first    (frame),
        .invert_b (cur_op == OP_SUB),
        .a        (acc_q[0]),
        .b        (op_bit),
        .sum      (add_sum)
    );

    // remember old bit 0 so a rotation can refill the top bit
    always_ff @(posedge clk) begin
        if (!rst_n)
            rot_lsb_q <= 1'b0;
        else if (bit_en && idx == '0)
            rot_lsb_q <= acc_q[0];
    end

    // select the bit written into the top of the accumulator
    always_comb begin
        unique case (cur_op)
            OP_LOAD:          acc_din = op_bit;
            OP_ADD, OP_SUB:   acc_din = add_sum;
            OP_ASR:           acc_din = last ? acc_q[0] : acc_q[1];
            OP_ROR:           acc_din = last ? rot_lsb_q : acc_q[1];
            OP_RELOAD:        acc_din = data_q[0];
            default:          acc_din = acc_q[0];
        endcase
        data_din = capture ? op_bit : data_q[0];
    end

    serial_word_reg #(.WORD_W(WORD_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (bit_en),
        .din      (acc_din),
        .q        (acc_q)
    );

    serial_word_reg #(.WORD_W(WORD_W)) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (bit_en),
        .din      (data_din),
        .q        (data_q)
    );

    // sign flag refreshed from the bit finishing the word
    always_ff @(posedge clk) begin
        if (!rst_n)
            sign_flag <= 1'b0;
        else if (bit_en && last)
            sign_flag <= acc_din;
    end

    assign res_bit = acc_q[0];

    // R10
    sign_follows_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && last) |=> (sign_flag == acc_q[WORD_W-1]));
    // R10
    sign_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_en && last) |=> $stable(sign_flag));
    // R3
    load_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && cur_op == OP_LOAD) |=> (acc_q[WORD_W-1] == $past(op_bit)));
    // R9
    data_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !capture) |=> (data_q[WORD_W-1] == $past(data_q[0])));
    // R11
    nop_recirc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && (cur_op == OP_NOP || cur_op == OP_STORE))
            |=> (acc_q[WORD_W-1] == $past(acc_q[0])));
endmodule

// File: tb/serial_acc_alu_tb.sv
// Bench: behavioural word-level model, bit outputs compared on every tick.
module serial_acc_alu_tb;
    import serial_alu_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       word_start = 1'b0;
    logic [2:0] op_sel = 3'd0;
    logic       op_bit = 1'b0;
    logic       res_bit;
    logic       sign_flag;

    int total = 0;
    int bad = 0;
    logic [31:0] acc_m = '0;
    logic [31:0] data_m = '0;
    logic        sign_m = 1'b0;

    always #4 clk = ~clk;

    serial_acc_alu u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .word_start (word_start),
        .op_sel     (op_sel),
        .op_bit     (op_bit),
        .res_bit    (res_bit),
        .sign_flag  (sign_flag)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // one word; stall_at >= 0 inserts idle cycles with junk inputs before that tick
    task automatic run_word(input logic [2:0] op, input logic [31:0] opnd,
                            input string req, input int stall_at);
        logic [31:0] start_acc;
        start_acc = acc_m;
        for (int k = 0; k < 32; k++) begin
            if (k == stall_at) begin
                for (int s = 0; s < 3; s++) begin
                    @(negedge clk);
                    bit_en = 1'b0; word_start = 1'b1;
                    op_sel = 3'($urandom); op_bit = 1'($urandom);
                    #1;
                    check("R2 stall res_bit", 32'(res_bit), 32'(start_acc[k]));
                    check("R10 stall sign", 32'(sign_flag), 32'(sign_m));
                end
            end
            @(negedge clk);
            bit_en = 1'b1; word_start = (k == 0);
            op_sel = (k == 0) ? op : 3'($urandom);
            op_bit = opnd[k];
            #1;
            check({req, " R6 res_bit"}, 32'(res_bit), 32'(start_acc[k]));
            if (k > 0)
                check("R10 sign hold", 32'(sign_flag), 32'(sign_m));
        end
        case (alu_op_e'(op))
            OP_LOAD:   begin acc_m = opnd;          data_m = opnd; end
            OP_ADD:    begin acc_m = acc_m + opnd;  data_m = opnd; end
            OP_SUB:    begin acc_m = acc_m - opnd;  data_m = opnd; end
            OP_ASR:    acc_m = 32'($signed(acc_m) >>> 1);
            OP_ROR:    acc_m = {acc_m[0], acc_m[31:1]};
            OP_RELOAD: acc_m = data_m;
            default:   ;
        endcase
        sign_m = acc_m[31];
        @(negedge clk);
        bit_en = 1'b0; word_start = 1'b0;
        #1;
        check({req, " R10 sign"}, 32'(sign_flag), 32'(sign_m));
    endtask

    // read the accumulator out with STORE (checks every bit through R6)
    task automatic readout(input string req);
        run_word(3'd4, 32'h0, req, -1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        #1;
        check("R1 res_bit", 32'(res_bit), 32'h0);
        check("R1 sign", 32'(sign_flag), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        readout("R1 acc zero");
        run_word(3'd7, 32'h0, "R1 data zero", -1);
        readout("R1 data readout");

        run_word(3'd1, 32'h1234_5678, "R3 load", -1);
        readout("R3 readout");
        run_word(3'd2, 32'h0FFF_0001, "R4 add", -1);
        readout("R4 readout");
        run_word(3'd1, 32'hFFFF_FFFF, "R3 load ones", -1);
        run_word(3'd2, 32'h0000_0001, "R4 add wrap", -1);
        readout("R4 wrap readout");
        run_word(3'd3, 32'h0000_0001, "R5 sub to neg", -1);
        readout("R5 readout");
        run_word(3'd3, 32'h7FFF_FFFF, "R5 sub overflow", -1);
        readout("R5 ovf readout");
        run_word(3'd1, 32'h8000_0000, "R3 load min", -1);
        run_word(3'd5, 32'h0, "R7 asr1", -1);
        run_word(3'd5, 32'h0, "R7 asr2", -1);
        run_word(3'd5, 32'h0, "R7 asr3", -1);
        readout("R7 readout");
        run_word(3'd1, 32'h4000_0003, "R3 load pos", -1);
        run_word(3'd5, 32'h0, "R7 asr pos", -1);
        run_word(3'd6, 32'h0, "R8 ror1", -1);
        run_word(3'd6, 32'h0, "R8 ror2", -1);
        readout("R8 readout");
        run_word(3'd1, 32'hA5A5_0F0F, "R9 capture", -1);
        run_word(3'd0, 32'hFFFF_FFFF, "R11 nop", -1);
        run_word(3'd6, 32'hFFFF_FFFF, "R9 no capture", -1);
        run_word(3'd7, 32'h0, "R9 reload", -1);
        readout("R9 readout");
        run_word(3'd2, 32'h1111_2222, "R2 stall add", 10);
        readout("R2 stall readout");
        run_word(3'd3, 32'h0000_0FFF, "R2 stall sub", 31);
        run_word(3'd7, 32'h0, "R2 stall reload", 0);
        readout("R2 final readout");
        for (int i = 0; i < 40; i++) begin
            run_word(3'($urandom), $urandom, "R4 random", (i % 5 == 0) ? int'($urandom_range(0, 31)) : -1);
            if (i % 4 == 0) readout("R6 random readout");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule